// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block accepts configuration words on a three-wire serial link made of a bit clock, a data line and a load strobe. It samples all three lines in its own system clock domain. On each rising edge of the bit clock it shifts the data line into a shift register, least significant bit first. The two bits shifted in last form a group code, and that code picks the destination of the word. On a rising edge of the load strobe the payload is copied into the control register, the feedback-divider register (swallow and main counts) or the reference-divider register.

The control register carries these settings: a phase-detector polarity bit, a pump-current select bit, a pump tri-state bit, five power-down bits (receiver, transmitter, oscillator core, synthesizer, crystal oscillator) and a two-bit test-output select. A small decoder turns them into section enables for a radio front end. A word with an illegal code, or with fewer bits than its group needs, is dropped and leaves every register unchanged.

Top module: `cfg_serial_if`

## Requirements
- R1: While reset is held and after its release, the control register reads 10'h0F8: bits 3 to 7 (all power-down bits) are 1 and every other bit is 0. The swallow, main and reference counts read 0.
- R2: A data bit is taken on each synchronized rising edge of the bit clock, least significant bit first. The group code is the last two bits shifted, and code[1] is the very last bit.
- R3: Code 2'b00 loads the 10 payload bits into the control register. Its bit 0 is polarity, bit 1 is pump current high, bit 2 is pump tri-state, bits 3 to 7 are the receiver, transmitter, oscillator core, synthesizer and crystal power-down bits, and bits 9:8 are the test select.
- R4: Code 2'b01 loads 13 payload bits. The first 5 bits shifted become the swallow count and the next 8 become the main count.
- R5: Code 2'b10 loads 6 payload bits into the reference count.
- R6: A word carrying code 2'b11 is discarded, and every register keeps its value.
- R7: A word with fewer bit-clock edges since the previous load than its payload width plus 2 is discarded.
- R8: When more bits than needed are shifted in, only the most recent payload-plus-code bits are used.
- R9: When a bit-clock rise and a load rise are seen in the same system cycle, the load uses the bits received before that edge. The new bit becomes the first bit of the next word.
- R10: The decoder gives these outputs. Doubler on = not (receiver off and transmitter off). Oscillator-core regulator on = not oscillator-core off. Synthesizer regulator on = not (synthesizer off and crystal off). Receive regulator on = not receiver off. Transmit regulator on = not transmitter off.
- R11: Loop open equals the pump tri-state bit. Pump drive is active only when the pump is not tri-stated and the synthesizer is not powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| ser_ld_i | input | 1 | Load strobe, acts on its rising edge |
| ctl_o | output | 10 | Control register |
| swl_o | output | 5 | Swallow count |
| main_o | output | 8 | Main count |
| ref_o | output | 6 | Reference count |
| dbl_on_o | output | 1 | Frequency doubler enable |
| osc_reg_on_o | output | 1 | Oscillator-core regulator enable |
| syn_reg_on_o | output | 1 | Synthesizer regulator enable |
| rx_reg_on_o | output | 1 | Receive regulator enable |
| tx_reg_on_o | output | 1 | Transmit regulator enable |
| loop_open_o | output | 1 | Loop open (pump tri-stated) |
| pump_drv_o | output | 1 | Charge pump actively driving |

## Verification
A bit-clock rise and a load rise can land in the same system cycle, so a shift and a commit happen together. The bench provokes this by raising both lines in one step after a complete reference-divider word. It then checks two things: the committed value excludes the concurrent bit, and the word that follows, completed with seven more bits, carries that bit as its bit 0.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  typedef enum logic [1:0] {
    GRP_CTL  = 2'b00,
    GRP_NDIV = 2'b01,
    GRP_RDIV = 2'b10,
    GRP_BAD  = 2'b11
  } grp_e;

  typedef struct packed {
    logic [1:0] tsel;
    logic       xo_off;
    logic       syn_off;
    logic       osc_off;
    logic       tx_off;
    logic       rx_off;
    logic       cp_tri;
    logic       cp_hi;
    logic       pol;
  } ctl_t;

  localparam logic [9:0] CTL_RESET = 10'h0F8;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;
    always_comb pipe_d = {pipe_q[STAGES-1:0], din[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end
    assign lvl[g]  = pipe_q[STAGES-1];
    assign rise[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int SW  = 15,
  parameter int CNW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           bit_val,
  input  logic           ld_en,
  output logic [SW-1:0]  sr,
  output logic [CNW-1:0] cnt
);
  logic [SW-1:0]  sr_d;
  logic [CNW-1:0] cnt_d;

  always_comb begin
    sr_d  = sr;
    cnt_d = cnt;
    if (bit_en) sr_d = {bit_val, sr[SW-1:1]};
    if (ld_en)
      cnt_d = bit_en ? CNW'(1) : '0;
    else if (bit_en && cnt != CNW'(SW))
      cnt_d = cnt + CNW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      sr  <= sr_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_serial_pkg::*;
#(
  parameter int SW    = 15,
  parameter int CNW   = 4,
  parameter int CTL_W = 10,
  parameter int A_W   = 5,
  parameter int B_W   = 8,
  parameter int R_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SW-1:0]    sr,
  input  logic [CNW-1:0]   cnt,
  output logic [CTL_W-1:0] ctl_q,
  output logic [A_W-1:0]   swl_q,
  output logic [B_W-1:0]   main_q,
  output logic [R_W-1:0]   ref_q,
  output grp_e             code
);
  localparam int TOP = SW - 3;
  localparam int NW  = A_W + B_W;

  logic [CTL_W-1:0] ctl_d;
  logic [A_W-1:0]   swl_d;
  logic [B_W-1:0]   main_d;
  logic [R_W-1:0]   ref_d;
  logic [NW-1:0]    npay;
  logic             ok_ctl, ok_n, ok_r;

  assign code = grp_e'(sr[SW-1 -: 2]);
  assign npay = sr[TOP -: NW];

  always_comb begin
    ok_ctl = ld_en && code == GRP_CTL  && cnt >= CNW'(CTL_W + 2);
    ok_n   = ld_en && code == GRP_NDIV && cnt >= CNW'(NW + 2);
    ok_r   = ld_en && code == GRP_RDIV && cnt >= CNW'(R_W + 2);
    ctl_d  = ok_ctl ? sr[TOP -: CTL_W] : ctl_q;
    swl_d  = ok_n ? npay[A_W-1:0] : swl_q;
    main_d = ok_n ? npay[NW-1:A_W] : main_q;
    ref_d  = ok_r ? sr[TOP -: R_W] : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      swl_q  <= '0;
      main_q <= '0;
      ref_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      swl_q  <= swl_d;
      main_q <= main_d;
      ref_q  <= ref_d;
    end
  end
endmodule

// File: rtl/cfg_power_decode.sv
module cfg_power_decode
  import cfg_serial_pkg::*;
(
  input  ctl_t ctl,
  output logic dbl_on,
  output logic osc_reg_on,
  output logic syn_reg_on,
  output logic rx_reg_on,
  output logic tx_reg_on,
  output logic loop_open,
  output logic pump_drv
);
  always_comb begin
    dbl_on     = ~(ctl.rx_off & ctl.tx_off);
    osc_reg_on = ~ctl.osc_off;
    syn_reg_on = ~(ctl.syn_off & ctl.xo_off);
    rx_reg_on  = ~ctl.rx_off;
    tx_reg_on  = ~ctl.tx_off;
    loop_open  = ctl.cp_tri;
    pump_drv   = ~ctl.cp_tri & ~ctl.syn_off;
  end
endmodule

// File: rtl/cfg_serial_if.sv
module cfg_serial_if
  import cfg_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int A_W         = 5,
  parameter int B_W         = 8,
  parameter int R_W         = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  input  logic        ser_ld_i,
  output logic [9:0]  ctl_o,
  output logic [4:0]  swl_o,
  output logic [7:0]  main_o,
  output logic [5:0]  ref_o,
  output logic        dbl_on_o,
  output logic        osc_reg_on_o,
  output logic        syn_reg_on_o,
  output logic        rx_reg_on_o,
  output logic        tx_reg_on_o,
  output logic        loop_open_o,
  output logic        pump_drv_o
);
  localparam int CTL_W = $bits(ctl_t);
  localparam int NW    = A_W + B_W;
  localparam int PMAX  = (NW > CTL_W) ? ((NW > R_W) ? NW : R_W)
                                      : ((CTL_W > R_W) ? CTL_W : R_W);
  localparam int SW    = PMAX + 2;
  localparam int CNW   = $clog2(SW + 1);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [2:0]     lvl, rise;
  logic [SW-1:0]  sr;
  logic [CNW-1:0] cnt;
  logic [CTL_W-1:0] ctl_q;
  grp_e           code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_sync_edge #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .din({ser_ld_i, ser_dat_i, ser_clk_i}),
    .lvl(lvl), .rise(rise)
  );

  cfg_shift_reg #(.SW(SW), .CNW(CNW)) u_sr (
    .clk(clk), .rst_n(rst_int_n),
    .bit_en(rise[0]), .bit_val(lvl[1]), .ld_en(rise[2]),
    .sr(sr), .cnt(cnt)
  );

  cfg_latch_bank #(.SW(SW), .CNW(CNW), .CTL_W(CTL_W), .A_W(A_W),
                   .B_W(B_W), .R_W(R_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .ld_en(rise[2]), .sr(sr), .cnt(cnt),
    .ctl_q(ctl_q), .swl_q(swl_o), .main_q(main_o), .ref_q(ref_o),
    .code(code)
  );

  cfg_power_decode u_dec (
    .ctl(ctl_t'(ctl_q)),
    .dbl_on(dbl_on_o), .osc_reg_on(osc_reg_on_o), .syn_reg_on(syn_reg_on_o),
    .rx_reg_on(rx_reg_on_o), .tx_reg_on(tx_reg_on_o),
    .loop_open(loop_open_o), .pump_drv(pump_drv_o)
  );

  assign ctl_o = ctl_q;
endmodule

// File: rtl/cfg_serial_if_chk.sv
module cfg_serial_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_rise,
  input logic [1:0] code,
  input logic [9:0] ctl,
  input logic [4:0] swl,
  input logic [7:0] mainc,
  input logic [5:0] refc,
  input logic       syn_reg_on,
  input logic       pump_drv,
  input logic       loop_open
);
  assert_ctl_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl != $past(ctl)) |-> ($past(ld_rise) && $past(code) == 2'b00));

  assert_ndiv_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({swl, mainc} != $past({swl, mainc})) |-> ($past(ld_rise) && $past(code) == 2'b01));

  assert_rdiv_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (refc != $past(refc)) |-> ($past(ld_rise) && $past(code) == 2'b10));

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && code == 2'b11) |=> $stable({ctl, swl, mainc, refc}));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable({ctl, swl, mainc, refc}));

  assert_syn_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_reg_on |-> (ctl[6] && ctl[7]));

  assert_pump_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pump_drv |-> (!loop_open && syn_reg_on));
endmodule

bind cfg_serial_if cfg_serial_if_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .ld_rise(rise[2]), .code(code),
  .ctl(ctl_o), .swl(swl_o), .mainc(main_o), .refc(ref_o),
  .syn_reg_on(syn_reg_on_o), .pump_drv(pump_drv_o), .loop_open(loop_open_o)
);

// File: tb/cfg_serial_if_test.sv
module cfg_serial_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic [9:0] ctl_o;
  logic [4:0] swl_o;
  logic [7:0] main_o;
  logic [5:0] ref_o;
  logic dbl_on, osc_on, syn_on, rx_on, tx_on, lopen, pdrv;

  int checks = 0;
  int errors = 0;
  logic [9:0] e_ctl;
  logic [4:0] e_swl;
  logic [7:0] e_main;
  logic [5:0] e_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_if uut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_i(ser_ld), .ctl_o(ctl_o), .swl_o(swl_o), .main_o(main_o),
    .ref_o(ref_o), .dbl_on_o(dbl_on), .osc_reg_on_o(osc_on),
    .syn_reg_on_o(syn_on), .rx_reg_on_o(rx_on), .tx_reg_on_o(tx_on),
    .loop_open_o(lopen), .pump_drv_o(pdrv)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic [31:0] w);
    for (int i = 0; i < n; i++) begin
      ser_dat = w[i];
      wait_cyc(HOLD);
      ser_clk = 1'b1;
      wait_cyc(HOLD);
      ser_clk = 1'b0;
    end
  endtask

  task automatic load();
    wait_cyc(HOLD);
    ser_ld = 1'b1;
    wait_cyc(HOLD);
    ser_ld = 1'b0;
    wait_cyc(6);
  endtask

  task automatic send_word(input int plen, input logic [1:0] code, input logic [31:0] pay);
    send_bits(plen + 2, pay | (32'(code) << plen));
    load();
  endtask

  task automatic check_all(input string req);
    chk(req, ctl_o, e_ctl);
    chk(req, swl_o, e_swl);
    chk(req, main_o, e_main);
    chk(req, ref_o, e_ref);
  endtask

  task automatic check_dec();
    chk("R10 dbl", dbl_on, !(e_ctl[3] && e_ctl[4]));
    chk("R10 osc", osc_on, !e_ctl[5]);
    chk("R10 syn", syn_on, !(e_ctl[6] && e_ctl[7]));
    chk("R10 rx", rx_on, !e_ctl[3]);
    chk("R10 tx", tx_on, !e_ctl[4]);
    chk("R11 open", lopen, e_ctl[2]);
    chk("R11 drv", pdrv, !e_ctl[2] && !e_ctl[6]);
  endtask

  initial begin
    wait_cyc(200000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    e_ctl = 10'h0F8; e_swl = '0; e_main = '0; e_ref = '0;
    wait_cyc(3);
    check_all("R1 in reset");
    rst_n = 1'b1;
    wait_cyc(5);
    check_all("R1 after reset");
    check_dec();

    // R3 / R10 / R11: control sweep
    for (int v = 0; v < 1024; v += 3) begin
      send_word(10, 2'b00, 32'(v));
      e_ctl = 10'(v);
      check_all("R3 control");
      check_dec();
    end
    // R5: full reference sweep
    for (int v = 0; v < 64; v++) begin
      send_word(6, 2'b10, 32'(v));
      e_ref = 6'(v);
      check_all("R5 reference");
    end
    // R4 / R2: divider patterns, swallow in low 5 bits
    for (int i = 0; i < 40; i++) begin
      logic [4:0] a = 5'(i * 7 + 3);
      logic [7:0] b = 8'(i * 37 + 11);
      send_word(13, 2'b01, 32'({b, a}));
      e_swl = a; e_main = b;
      check_all("R4 divider");
    end
    // R6: illegal code
    send_word(13, 2'b11, 32'h1FFF);
    check_all("R6 code 11");
    send_word(10, 2'b11, 32'h155);
    check_all("R6 code 11 short");
    // R7: too few bits for each group
    send_word(9, 2'b00, 32'h0AA);
    check_all("R7 short control");
    send_word(12, 2'b01, 32'h0ABC);
    check_all("R7 short divider");
    send_word(5, 2'b10, 32'h15);
    check_all("R7 short reference");
    // R8: leading garbage bits then a reference word
    send_bits(5, 32'h1B);
    send_word(6, 2'b10, 32'h2D);
    e_ref = 6'h2D;
    check_all("R8 extra bits");
    // R9: bit clock and load rise together
    send_bits(8, 32'((2'b10 << 6) | 6'h15));
    ser_dat = 1'b1;
    wait_cyc(HOLD);
    ser_clk = 1'b1; ser_ld = 1'b1;
    wait_cyc(HOLD);
    ser_clk = 1'b0; ser_ld = 1'b0;
    wait_cyc(6);
    e_ref = 6'h15;
    check_all("R9 concurrent commit");
    send_bits(7, 32'((2'b10 << 5) | 5'h0C));
    load();
    e_ref = 6'h19;
    check_all("R9 carried bit");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule